// File: doc/BRIEF.md
# Partial-Width Access Register File

This block is the architectural integer register bank of a processor core. It holds sixteen 64-bit registers and serves two combinational read ports and one clocked write port. Each port carries a register index and a three-bit size code. The code selects one of five views of the register: the whole word, the low 32 bits, the low 16 bits, the low byte, or the byte in bits 15:8. That last view exists only for the first four registers.

Reads return the selected field right-aligned, with the bits above it cleared. A write merges the new field into the stored word, and the merge rule depends on the size. A 32-bit write fills the upper half with copies of bit 31 of the written value. A 16-bit or byte write leaves every other bit of the register untouched. A request with an undefined size code is reported as illegal, and so is a high-byte request to an index above 3. An illegal write changes nothing.

By convention, index 0 holds the accumulator and index 1 the loop counter. Index 2 is the data register and index 3 the base register. Index 4 is the stack pointer, index 5 the frame base, and indices 6 and 7 the source and destination indices. The bank itself treats all sixteen registers alike, apart from the high-byte rule.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous active-high reset clears all sixteen 64-bit registers (indices 0 to 15) to zero.
- R2: Size codes are 3'b000 = full 64 bits, 3'b001 = bits 31:0, 3'b010 = bits 15:0, 3'b011 = bits 7:0, 3'b100 = bits 15:8. Codes 3'b101 to 3'b111 are illegal on any port.
- R3: A legal read returns the selected field in the low bits of its data output, and every bit above the field is zero.
- R4: The two read ports are independent: each one returns the field that its own index and size code select, in the same cycle.
- R5: A legal 32-bit write stores data bits 31:0 into register bits 31:0 and fills register bits 63:32 with copies of data bit 31.
- R6: A legal 16-bit or low-byte write replaces only register bits 15:0 or 7:0, taking them from the same data bits. All other register bits keep their values.
- R7: A legal high-byte write stores data bits 7:0 into register bits 15:8 and leaves all other register bits unchanged.
- R8: The high-byte code is legal only for indices 0 to 3. For any other index, the port's illegal flag is raised and the read data is zero. Any illegal read also returns zero.
- R9: When write enable is high and the request is illegal, the write illegal flag is raised and no register changes.
- R10: A read of the register being written in the same cycle returns the old contents. The new value is readable from the cycle after the write edge.
- R11: A legal full-width write replaces all 64 bits of the register with the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_sz | input | 3 | Read port 0 size code |
| rd0_data | output | 64 | Read port 0 field, right-aligned |
| rd0_illegal | output | 1 | Read port 0 request is illegal |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_sz | input | 3 | Read port 1 size code |
| rd1_data | output | 64 | Read port 1 field, right-aligned |
| rd1_illegal | output | 1 | Read port 1 request is illegal |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_sz | input | 3 | Write size code |
| wr_data | input | 64 | Write data, field taken from the low bits |
| wr_illegal | output | 1 | Write requested with an illegal index and size pair |

## Verification
A corrupted register, or a wrong merge, stays hidden until that register is read back with a size that covers the damaged bits. The bench therefore reads random registers at random sizes on both ports in every cycle. It compares each result with a bench model, so a bad write shows up on the first later read that overlaps it. A merge that corrupts the upper half is caught on the next full-width read of that register. A lost or spurious write to an illegal target is caught on the next read of the addressed register. A broken same-cycle read shows up immediately, because the read data then carries the new value one cycle too early.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [2:0] {
    SZ_FULL = 3'b000,
    SZ_LO32 = 3'b001,
    SZ_LO16 = 3'b010,
    SZ_LO8  = 3'b011,
    SZ_HI8  = 3'b100
  } gpr_size_e;

  // legality of an index/size pair; hi_ok says the index owns a high byte
  function automatic logic size_is_legal(input logic [2:0] sz, input logic hi_ok);
    logic ok;
    case (sz)
      SZ_FULL, SZ_LO32, SZ_LO16, SZ_LO8: ok = 1'b1;
      SZ_HI8:                            ok = hi_ok;
      default:                           ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NREGS   = 16,
  parameter int unsigned HB_REGS = 4,
  localparam int unsigned IW     = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] regs_i [NREGS],
  input  logic [IW-1:0]   idx_i,
  input  logic [2:0]      sz_i,
  output logic [XLEN-1:0] data_o,
  output logic            illegal_o
);

  function automatic logic [XLEN-1:0] pick_field(input logic [XLEN-1:0] v,
                                                 input logic [2:0] sz);
    logic [XLEN-1:0] r;
    r = '0;
    case (sz)
      SZ_FULL: r = v;
      SZ_LO32: r[31:0] = v[31:0];
      SZ_LO16: r[15:0] = v[15:0];
      SZ_LO8:  r[7:0]  = v[7:0];
      SZ_HI8:  r[7:0]  = v[15:8];
      default: r = '0;
    endcase
    return r;
  endfunction

  logic [XLEN-1:0] sel_word;
  logic            req_ok;

  assign sel_word  = regs_i[idx_i];
  assign req_ok    = size_is_legal(sz_i, 32'(idx_i) < HB_REGS);
  assign illegal_o = ~req_ok;
  assign data_o    = req_ok ? pick_field(sel_word, sz_i) : '0;

  // R8: an illegal request yields zero data
  a_r8_illegal_reads_zero: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (data_o == '0));

  // R3: a byte-wide view never sets bits above the byte
  a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (sz_i == SZ_LO8 || sz_i == SZ_HI8) |-> (data_o[XLEN-1:8] == '0));

  // R3: a 16-bit view never sets bits above bit 15
  a_r3_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (sz_i == SZ_LO16) |-> (data_o[XLEN-1:16] == '0));

endmodule

// File: rtl/gpr_wr_merge.sv
module gpr_wr_merge
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NREGS   = 16,
  parameter int unsigned HB_REGS = 4,
  localparam int unsigned IW     = $clog2(NREGS)
) (
  input  logic [XLEN-1:0] cur_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [2:0]      sz_i,
  input  logic [XLEN-1:0] data_i,
  output logic [XLEN-1:0] next_o,
  output logic            bad_o
);

  function automatic logic [XLEN-1:0] merge_field(input logic [XLEN-1:0] cur,
                                                  input logic [XLEN-1:0] d,
                                                  input logic [2:0] sz);
    logic [XLEN-1:0] r;
    r = cur;
    case (sz)
      SZ_FULL: r = d;
      SZ_LO32: r = {{(XLEN-32){d[31]}}, d[31:0]};
      SZ_LO16: r[15:0] = d[15:0];
      SZ_LO8:  r[7:0]  = d[7:0];
      SZ_HI8:  r[15:8] = d[7:0];
      default: r = cur;
    endcase
    return r;
  endfunction

  assign bad_o  = ~size_is_legal(sz_i, 32'(idx_i) < HB_REGS);
  assign next_o = merge_field(cur_i, data_i, sz_i);

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NREGS   = 16,
  parameter int unsigned HB_REGS = 4,
  localparam int unsigned IW     = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   rd0_idx,
  input  logic [2:0]      rd0_sz,
  output logic [XLEN-1:0] rd0_data,
  output logic            rd0_illegal,
  input  logic [IW-1:0]   rd1_idx,
  input  logic [2:0]      rd1_sz,
  output logic [XLEN-1:0] rd1_data,
  output logic            rd1_illegal,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [2:0]      wr_sz,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_illegal
);

  logic [XLEN-1:0] stor     [NREGS];
  logic [XLEN-1:0] wr_cur;
  logic [XLEN-1:0] wr_next;
  logic            wr_bad;
  logic            wr_commit;
  logic [NREGS-1:0] wr_hit;

  assign wr_cur     = stor[wr_idx];
  assign wr_commit  = wr_en & ~wr_bad;
  assign wr_illegal = wr_en & wr_bad;

  gpr_wr_merge #(.XLEN(XLEN), .NREGS(NREGS), .HB_REGS(HB_REGS)) u_merge (
    .cur_i  (wr_cur),
    .idx_i  (wr_idx),
    .sz_i   (wr_sz),
    .data_i (wr_data),
    .next_o (wr_next),
    .bad_o  (wr_bad)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [XLEN-1:0] q;
    assign wr_hit[g] = wr_commit && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (rst)            q <= '0;
      else if (wr_hit[g]) q <= wr_next;
    end
    assign stor[g] = q;

    // R1: reset clears every register
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (q == '0));
  end

  gpr_rd_port #(.XLEN(XLEN), .NREGS(NREGS), .HB_REGS(HB_REGS)) u_rd0 (
    .clk       (clk),
    .rst       (rst),
    .regs_i    (stor),
    .idx_i     (rd0_idx),
    .sz_i      (rd0_sz),
    .data_o    (rd0_data),
    .illegal_o (rd0_illegal)
  );

  gpr_rd_port #(.XLEN(XLEN), .NREGS(NREGS), .HB_REGS(HB_REGS)) u_rd1 (
    .clk       (clk),
    .rst       (rst),
    .regs_i    (stor),
    .idx_i     (rd1_idx),
    .sz_i      (rd1_sz),
    .data_o    (rd1_data),
    .illegal_o (rd1_illegal)
  );

  // R9: at most one register is updated per cycle
  a_r9_single_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));

  // R5: a 32-bit write sign-fills the upper half
  a_r5_lo32_extend: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_sz == SZ_LO32) |=>
      (stor[$past(wr_idx)] == {{(XLEN-32){$past(wr_data[31])}}, $past(wr_data[31:0])}));

  // R6: a 16-bit write keeps everything above bit 15
  a_r6_lo16_keeps_upper: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_sz == SZ_LO16) |=>
      (stor[$past(wr_idx)][XLEN-1:16] == $past(wr_cur[XLEN-1:16])));

  // R6: a low-byte write keeps everything above bit 7
  a_r6_lo8_keeps_upper: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_sz == SZ_LO8) |=>
      (stor[$past(wr_idx)][XLEN-1:8] == $past(wr_cur[XLEN-1:8])));

  // R7: a high-byte write lands in bits 15:8 and keeps the low byte
  a_r7_hi8_placement: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_sz == SZ_HI8) |=>
      ((stor[$past(wr_idx)][15:8] == $past(wr_data[7:0])) &&
       (stor[$past(wr_idx)][7:0]  == $past(wr_cur[7:0]))));

  // R9: an illegal write leaves the addressed register as it was
  a_r9_illegal_write_inert: assert property (@(posedge clk) disable iff (rst)
    wr_illegal |=> (stor[$past(wr_idx)] == $past(wr_cur)));

endmodule

// File: tb/test_gpr_bank.sv
module test_gpr_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [2:0]  rd0_sz = '0, rd1_sz = '0, wr_sz = '0;
  logic [63:0] rd0_data, rd1_data, wr_data = '0;
  logic        rd0_illegal, rd1_illegal, wr_en = 1'b0, wr_illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [63:0] mdl [16];

  always #10 clk = ~clk;

  gpr_bank i_gpr_bank (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_sz(rd0_sz), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_idx(rd1_idx), .rd1_sz(rd1_sz), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sz(wr_sz), .wr_data(wr_data), .wr_illegal(wr_illegal)
  );

  function automatic bit ok_pair(input logic [3:0] idx, input logic [2:0] sz);
    return (sz <= 3'd3) || (sz == 3'd4 && idx < 4'd4);
  endfunction

  function automatic logic [63:0] view(input logic [63:0] v, input logic [3:0] idx,
                                       input logic [2:0] sz);
    if (!ok_pair(idx, sz)) return 64'h0;
    case (sz)
      3'd0:    return v;
      3'd1:    return v & 64'h0000_0000_FFFF_FFFF;
      3'd2:    return v & 64'hFFFF;
      3'd3:    return v & 64'hFF;
      default: return (v >> 8) & 64'hFF;
    endcase
  endfunction

  function automatic logic [63:0] apply(input logic [63:0] old, input logic [63:0] d,
                                        input logic [2:0] sz);
    case (sz)
      3'd0:    return d;
      3'd1:    return {{32{d[31]}}, d[31:0]};
      3'd2:    return (old & ~64'hFFFF) | (d & 64'hFFFF);
      3'd3:    return (old & ~64'hFF) | (d & 64'hFF);
      default: return (old & ~64'hFF00) | ((d & 64'hFF) << 8);
    endcase
  endfunction

  task automatic check(input bit cond, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive, check reads and flag against the model, then advance the model
  task automatic cyc(input string tag, input bit we, input logic [3:0] widx,
                     input logic [2:0] wsz, input logic [63:0] wd,
                     input logic [3:0] ai, input logic [2:0] as,
                     input logic [3:0] bi, input logic [2:0] bs);
    logic [63:0] e0, e1;
    @(negedge clk);
    wr_en = we; wr_idx = widx; wr_sz = wsz; wr_data = wd;
    rd0_idx = ai; rd0_sz = as; rd1_idx = bi; rd1_sz = bs;
    #2;
    e0 = view(mdl[ai], ai, as);
    e1 = view(mdl[bi], bi, bs);
    check(rd0_data == e0, tag, rd0_data, e0);
    check(rd1_data == e1, {tag, "/R4"}, rd1_data, e1);
    check(rd0_illegal == !ok_pair(ai, as), {tag, "/R8 rd0 flag"}, 64'(rd0_illegal), 64'(!ok_pair(ai, as)));
    check(rd1_illegal == !ok_pair(bi, bs), {tag, "/R8 rd1 flag"}, 64'(rd1_illegal), 64'(!ok_pair(bi, bs)));
    check(wr_illegal == (we && !ok_pair(widx, wsz)), {tag, "/R9 wr flag"},
          64'(wr_illegal), 64'(we && !ok_pair(widx, wsz)));
    if (we && ok_pair(widx, wsz)) mdl[widx] = apply(mdl[widx], wd, wsz);
  endtask

  // read only, compare port 0 with a literal value
  task automatic peek(input string tag, input logic [3:0] idx, input logic [2:0] sz,
                      input logic [63:0] exp);
    @(negedge clk);
    wr_en = 1'b0; rd0_idx = idx; rd0_sz = sz;
    #2;
    check(rd0_data == exp, tag, rd0_data, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 64'h0;
    // load junk, then reset must clear it
    @(negedge clk); rst = 1'b0; wr_en = 1'b1; wr_idx = 4'd6; wr_sz = 3'd0; wr_data = 64'hBAD;
    @(negedge clk); wr_en = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;

    // R1: every register reads zero after reset
    for (int i = 0; i < 16; i += 2) cyc("R1", 1'b0, 0, 0, 0, 4'(i), 3'd0, 4'(i + 1), 3'd0);

    // R11 full write, then R2/R3 views
    cyc("R11", 1'b1, 4'd0, 3'd0, 64'h0123_4567_89AB_CDEF, 0, 0, 1, 0);
    peek("R11 full", 4'd0, 3'd0, 64'h0123_4567_89AB_CDEF);
    peek("R2/R3 lo32", 4'd0, 3'd1, 64'h89AB_CDEF);
    peek("R2/R3 lo16", 4'd0, 3'd2, 64'hCDEF);
    peek("R2/R3 lo8",  4'd0, 3'd3, 64'hEF);
    peek("R2/R3 hi8",  4'd0, 3'd4, 64'hCD);

    // R5 sign fill both ways
    cyc("R5", 1'b1, 4'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
    cyc("R5", 1'b1, 4'd1, 3'd1, 64'hDEAD_BEEF_7FFF_FFFF, 0, 0, 0, 0);
    peek("R5 positive", 4'd1, 3'd0, 64'h0000_0000_7FFF_FFFF);
    cyc("R5", 1'b1, 4'd1, 3'd1, 64'h0000_0000_8000_0000, 0, 0, 0, 0);
    peek("R5 negative", 4'd1, 3'd0, 64'hFFFF_FFFF_8000_0000);

    // R6 / R7 narrow merges
    cyc("R6", 1'b1, 4'd2, 3'd0, 64'h1111_1111_1111_1111, 0, 0, 0, 0);
    cyc("R6", 1'b1, 4'd2, 3'd2, 64'hFFFF_FFFF_FFFF_ABCD, 0, 0, 0, 0);
    peek("R6 lo16", 4'd2, 3'd0, 64'h1111_1111_1111_ABCD);
    cyc("R6", 1'b1, 4'd2, 3'd3, 64'hFFFF_FFFF_FFFF_FF55, 0, 0, 0, 0);
    peek("R6 lo8", 4'd2, 3'd0, 64'h1111_1111_1111_AB55);
    cyc("R7", 1'b1, 4'd2, 3'd4, 64'hFFFF_FFFF_FFFF_FF77, 0, 0, 0, 0);
    peek("R7 hi8", 4'd2, 3'd0, 64'h1111_1111_1111_7755);

    // R8 / R9 illegal requests
    cyc("R8", 1'b1, 4'd5, 3'd0, 64'h5555_AAAA_5555_AAAA, 4'd5, 3'd4, 4'd4, 3'd4);
    peek("R8 hi8 idx5 zero", 4'd5, 3'd4, 64'h0);
    cyc("R9", 1'b1, 4'd5, 3'd4, 64'hFF, 0, 0, 0, 0);
    peek("R9 hi8 idx5 unchanged", 4'd5, 3'd0, 64'h5555_AAAA_5555_AAAA);
    cyc("R9", 1'b1, 4'd0, 3'd5, 64'h0, 4'd0, 3'd7, 4'd3, 3'd6);
    peek("R9 code5 unchanged", 4'd0, 3'd0, 64'h0123_4567_89AB_CDEF);

    // R10 same-cycle read sees old value
    cyc("R10", 1'b1, 4'd3, 3'd0, 64'hCAFE_F00D_1234_5678, 4'd3, 3'd0, 4'd3, 3'd1);
    peek("R10 next cycle", 4'd3, 3'd0, 64'hCAFE_F00D_1234_5678);

    // random traffic
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  wi, ai, bi;
      logic [2:0]  ws, as, bs;
      logic [63:0] wd;
      wi = 4'($urandom % 16); ws = 3'($urandom % 8);
      ai = (n % 3 == 0) ? wi : 4'($urandom % 16);
      as = 3'($urandom % 8); bi = 4'($urandom % 16); bs = 3'($urandom % 8);
      wd = {$urandom, $urandom};
      cyc("R3 random", ($urandom % 4) != 0, wi, ws, wd, ai, as, bi, bs);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule